// File: doc/BRIEF.md
# Overlay-Aware Memory Map Decoder

This block sits on the data side of a 16-bit processor bus that carries a 23-bit word address. Each cycle in which the data strobe is active, the decoder picks one of three targets: an internal RAM, an internal ROM, or an external I/O region. It then performs the word or byte read or write against that target. Where the boundary between RAM and ROM falls depends on a registered overlay control. Overlay comes out of reset set, which puts ROM at address zero for boot code. Clearing it moves RAM down to address zero.

Both arrays have power-of-two depths set by parameters. Each is indexed by the word address modulo its depth, so one physical array appears many times across its window. ROM content is generated from a fixed formula of the word index, so no image file is needed. Writes that decode to ROM are dropped without a trace. I/O cycles leave on a plain select/strobe interface, and the device answers on the same cycle. A separate combinational flag marks any address that belongs to the slow peripheral bus.

Read results are registered. They appear on `rdata` after the clock edge that ends the cycle and hold until the next completed read.

Top module: `memmap_decoder`

## Requirements
- R1: A word address at or above 0x400000 selects the I/O region. Such a cycle asserts `io_sel` (and `io_we` when it is a write) and never reads or writes RAM or ROM.
- R2: With overlay set, word addresses below 0x300000 decode to ROM and addresses 0x300000 to 0x3FFFFF decode to RAM. ROM is therefore visible at both 0x000000 and 0x200000.
- R3: With overlay clear, word addresses below 0x200000 decode to RAM and addresses 0x200000 to 0x3FFFFF decode to ROM.
- R4: The selected array is indexed by the word address modulo its depth in words. Both depths must be powers of two.
- R5: A write that decodes to ROM changes no stored state. A later read of that location returns the original ROM word.
- R6: On a byte write, `cyc_lsb`=0 replaces bits 15:8 and `cyc_lsb`=1 replaces bits 7:0, in both cases taking the data from `cyc_wdata[7:0]`. The other byte keeps its old value.
- R7: A byte read returns the selected byte on bits 7:0 with bits 15:8 zero. For RAM and ROM, `cyc_lsb`=0 selects bits 15:8 and `cyc_lsb`=1 selects bits 7:0. For I/O, the byte is taken from `io_rdata[7:0]`.
- R8: `periph_o` is high, combinationally and independent of the strobe, exactly when the word address is at or above 0x700000.
- R9: An I/O read with `io_hit` low returns 0xFFFF for a word access and 0x00FF for a byte access. With `io_hit` high it returns `io_rdata`.
- R10: A cycle with `cyc_valid` low, or with `cyc_iack` high, performs no access, asserts no `io_sel`, and leaves `rdata` unchanged.
- R11: Overlay is sampled from `overlay_in` at each clock edge and resets to 1. A change is used for decode starting with the cycle after the edge that samples it.
- R12: `rdata` resets to 0x0000 and takes a read's result at the clock edge that ends that read cycle.
- R13: The ROM word at index i holds ((i × 0x3C5B) mod 2^16) XOR 0xA5C3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | Data strobe active this cycle |
| cyc_iack | input | 1 | Interrupt-acknowledge cycle (no access) |
| cyc_read | input | 1 | 1 = read, 0 = write |
| cyc_word | input | 1 | 1 = word access, 0 = byte access |
| cyc_lsb | input | 1 | Byte-address LSB for byte lanes |
| cyc_addr | input | 23 | Word address |
| cyc_wdata | input | 16 | Write data |
| overlay_in | input | 1 | ROM overlay control |
| io_hit | input | 1 | I/O device recognised the address |
| io_rdata | input | 16 | I/O device read data |
| rdata | output | 16 | Registered read data |
| periph_o | output | 1 | Address lies on the slow peripheral bus |
| io_sel | output | 1 | I/O cycle strobe |
| io_we | output | 1 | I/O write strobe |
| io_addr | output | 23 | I/O word address |
| io_wdata | output | 16 | I/O write data |
| io_word | output | 1 | I/O access is word-sized |
| io_lsb | output | 1 | I/O byte-address LSB |

## Verification
The hardest case to reach is the one-cycle lag of the overlay control. In the cycle where `overlay_in` changes, a read must still decode with the old setting, and only the following read may see the new map. The bench drives the toggle together with a read of an address whose target differs between the two settings, then repeats the read in the next cycle. It does this in both directions. A discarded ROM write can only be seen as the absence of a change, so the bench writes through each mapping's ROM window and reads the location back through ROM. It also fills RAM through the overlay window and reads it back through the low window, which shows that both views reach the same storage.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

   typedef enum logic [1:0] {
      TGT_RAM = 2'd0,
      TGT_ROM = 2'd1,
      TGT_IO  = 2'd2
   } tgt_e;

   localparam logic [15:0] ROM_MULT = 16'h3C5B;
   localparam logic [15:0] ROM_SALT = 16'hA5C3;

   // Generated ROM content: scrambled index, no image file needed.
   function automatic logic [15:0] rom_word(input logic [15:0] idx);
      logic [31:0] prod;
      prod = {16'h0000, idx} * {16'h0000, ROM_MULT};
      return prod[15:0] ^ ROM_SALT;
   endfunction

endpackage

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
   import memmap_pkg::*;
#(
   parameter int           AW            = 23,
   parameter logic [AW-1:0] NORM_ROM_BASE = 23'h200000,
   parameter logic [AW-1:0] OVL_RAM_BASE  = 23'h300000,
   parameter logic [AW-1:0] IO_BASE       = 23'h400000,
   parameter logic [AW-1:0] PERIPH_BASE   = 23'h700000
) (
   input  logic [AW-1:0] addr,
   input  logic          overlay,
   output tgt_e          tgt,
   output logic          periph
);

   logic in_io;
   logic rom_when_ovl;
   logic rom_when_norm;

   assign in_io         = (addr >= IO_BASE);
   assign rom_when_ovl  = (addr <  OVL_RAM_BASE);
   assign rom_when_norm = (addr >= NORM_ROM_BASE);
   assign periph        = (addr >= PERIPH_BASE);

   always_comb begin
      if (in_io)
         tgt = TGT_IO;
      else if (overlay ? rom_when_ovl : rom_when_norm)
         tgt = TGT_ROM;
      else
         tgt = TGT_RAM;
   end

endmodule

// File: rtl/memmap_ram.sv
module memmap_ram #(
   parameter int WORDS = 1024,
   localparam int IW = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic [1:0]    lane_we,
   input  logic [IW-1:0] widx,
   input  logic [15:0]   wdata,
   input  logic [IW-1:0] ridx,
   output logic [15:0]   rdata
);

   // One byte-wide array per lane so a byte write never reads the word back.
   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [7:0] mem [WORDS];
      always_ff @(posedge clk) begin
         if (lane_we[g])
            mem[widx] <= wdata[g*8 +: 8];
      end
      assign rdata[g*8 +: 8] = mem[ridx];
   end

endmodule

// File: rtl/memmap_rom.sv
module memmap_rom
   import memmap_pkg::*;
#(
   parameter int WORDS = 1024,
   localparam int IW = $clog2(WORDS)
) (
   input  logic [IW-1:0] idx,
   output logic [15:0]   rdata
);

   logic [15:0] idx16;

   if (IW >= 16) begin : g_wide
      assign idx16 = idx[15:0];
   end else begin : g_narrow
      assign idx16 = {{(16-IW){1'b0}}, idx};
   end

   assign rdata = rom_word(idx16);

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
   import memmap_pkg::*;
#(
   parameter int            AW            = 23,
   parameter int            RAM_WORDS     = 1024,
   parameter int            ROM_WORDS     = 1024,
   parameter logic [AW-1:0] NORM_ROM_BASE = 23'h200000,
   parameter logic [AW-1:0] OVL_RAM_BASE  = 23'h300000,
   parameter logic [AW-1:0] IO_BASE       = 23'h400000,
   parameter logic [AW-1:0] PERIPH_BASE   = 23'h700000,
   localparam int RAM_IW = $clog2(RAM_WORDS),
   localparam int ROM_IW = $clog2(ROM_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cyc_valid,
   input  logic          cyc_iack,
   input  logic          cyc_read,
   input  logic          cyc_word,
   input  logic          cyc_lsb,
   input  logic [AW-1:0] cyc_addr,
   input  logic [15:0]   cyc_wdata,
   input  logic          overlay_in,
   input  logic          io_hit,
   input  logic [15:0]   io_rdata,
   output logic [15:0]   rdata,
   output logic          periph_o,
   output logic          io_sel,
   output logic          io_we,
   output logic [AW-1:0] io_addr,
   output logic [15:0]   io_wdata,
   output logic          io_word,
   output logic          io_lsb
);

   // Elaboration-time parameter checks
   if ((1 << RAM_IW) != RAM_WORDS || RAM_IW < 1 || RAM_IW > AW) begin : g_bad_ram
      $error("RAM_WORDS must be a power of two within the address space");
   end
   if ((1 << ROM_IW) != ROM_WORDS || ROM_IW < 1 || ROM_IW > AW) begin : g_bad_rom
      $error("ROM_WORDS must be a power of two within the address space");
   end
   if (!(NORM_ROM_BASE < OVL_RAM_BASE && OVL_RAM_BASE <= IO_BASE && IO_BASE <= PERIPH_BASE)) begin : g_bad_map
      $error("region bases must ascend");
   end

   logic        ovl_q;
   tgt_e        tgt;
   logic        act;
   logic [1:0]  ram_we;
   logic [15:0] ram_wd;
   logic [15:0] ram_rd;
   logic [15:0] rom_rd;
   logic [15:0] word_sel;
   logic [15:0] shaped;

   // Overlay control: sampled, boots with ROM at zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovl_q <= 1'b1;
      else        ovl_q <= overlay_in;
   end

   memmap_region_dec #(
      .AW(AW), .NORM_ROM_BASE(NORM_ROM_BASE), .OVL_RAM_BASE(OVL_RAM_BASE),
      .IO_BASE(IO_BASE), .PERIPH_BASE(PERIPH_BASE)
   ) u_dec (
      .addr(cyc_addr), .overlay(ovl_q), .tgt(tgt), .periph(periph_o)
   );

   assign act = cyc_valid & ~cyc_iack;

   // RAM write lanes; ROM targets never raise a lane enable
   always_comb begin
      ram_we = 2'b00;
      if (act && !cyc_read && tgt == TGT_RAM) begin
         ram_we[1] = cyc_word | ~cyc_lsb;
         ram_we[0] = cyc_word |  cyc_lsb;
      end
   end
   assign ram_wd = {cyc_word ? cyc_wdata[15:8] : cyc_wdata[7:0], cyc_wdata[7:0]};

   memmap_ram #(.WORDS(RAM_WORDS)) u_ram (
      .clk(clk), .lane_we(ram_we), .widx(cyc_addr[RAM_IW-1:0]), .wdata(ram_wd),
      .ridx(cyc_addr[RAM_IW-1:0]), .rdata(ram_rd)
   );

   memmap_rom #(.WORDS(ROM_WORDS)) u_rom (
      .idx(cyc_addr[ROM_IW-1:0]), .rdata(rom_rd)
   );

   // Read path
   always_comb begin
      unique case (tgt)
         TGT_RAM: word_sel = ram_rd;
         TGT_ROM: word_sel = rom_rd;
         default: word_sel = io_hit ? io_rdata : 16'hFFFF;
      endcase
      if (cyc_word)
         shaped = word_sel;
      else if (tgt == TGT_IO || cyc_lsb)
         shaped = {8'h00, word_sel[7:0]};
      else
         shaped = {8'h00, word_sel[15:8]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               rdata <= 16'h0000;
      else if (act && cyc_read) rdata <= shaped;
   end

   // I/O strobe interface
   assign io_sel   = act & (tgt == TGT_IO);
   assign io_we    = io_sel & ~cyc_read;
   assign io_addr  = cyc_addr;
   assign io_wdata = cyc_wdata;
   assign io_word  = cyc_word;
   assign io_lsb   = cyc_lsb;

   // Assertions
   p_io_no_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      io_sel |-> (ram_we == 2'b00));

   p_rom_write_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !cyc_read && tgt == TGT_ROM) |-> (ram_we == 2'b00));

   p_byte_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && cyc_read && !cyc_word) |=> (rdata[15:8] == 8'h00));

   p_periph_in_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
      periph_o |-> (tgt == TGT_IO));

   p_unrec_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel && cyc_read && cyc_word && !io_hit) |=> (rdata == 16'hFFFF));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(act && cyc_read) |=> $stable(rdata));

   p_lane_onehot_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !cyc_word) |-> $onehot0(ram_we));

endmodule

// File: tb/memmap_decoder_bench.sv
module memmap_decoder_bench;

   localparam int RAM_W = 1024;
   localparam int ROM_W = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_valid = 1'b0, cyc_iack = 1'b0, cyc_read = 1'b0;
   logic        cyc_word = 1'b0, cyc_lsb = 1'b0;
   logic [22:0] cyc_addr = '0;
   logic [15:0] cyc_wdata = '0;
   logic        overlay_in = 1'b1;
   logic        io_hit = 1'b0;
   logic [15:0] io_rdata = '0;
   logic [15:0] rdata;
   logic        periph_o, io_sel, io_we, io_word, io_lsb;
   logic [22:0] io_addr;
   logic [15:0] io_wdata;

   always #10 clk = ~clk;

   memmap_decoder u_memmap_decoder (
      .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_iack(cyc_iack),
      .cyc_read(cyc_read), .cyc_word(cyc_word), .cyc_lsb(cyc_lsb),
      .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .overlay_in(overlay_in),
      .io_hit(io_hit), .io_rdata(io_rdata), .rdata(rdata), .periph_o(periph_o),
      .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_word(io_word), .io_lsb(io_lsb)
   );

   int checks = 0;
   int fails  = 0;

   // Reference model state
   logic [15:0] ram_m [RAM_W];
   bit          ovl_m = 1'b1;
   logic [15:0] exp_rd = 16'h0000;

   function automatic logic [15:0] rom_f(int i);
      int unsigned t;
      t = (i * 15451) % 65536;
      return 16'(t) ^ 16'hA5C3;
   endfunction

   task automatic chk(string tag, logic [15:0] got, logic [15:0] want);
      checks++;
      if (got !== want) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, want);
      end
   endtask

   // One bus cycle: drive after a falling edge, check strobes, model at the
   // rising edge, check registered data at the next falling edge.
   task automatic cyc(string tag, bit v, bit ia, bit rd, bit wd, bit lsb,
                      int a, logic [15:0] wdat, bit ovl, bit hit, logic [15:0] iod);
      int tgt;
      int ri;
      int oi;
      logic [15:0] w;
      cyc_valid = v; cyc_iack = ia; cyc_read = rd; cyc_word = wd; cyc_lsb = lsb;
      cyc_addr = 23'(a); cyc_wdata = wdat; overlay_in = ovl; io_hit = hit; io_rdata = iod;
      #1;
      chk({tag, " periph"}, {15'd0, periph_o}, {15'd0, a >= 'h700000});
      chk({tag, " io_sel"}, {15'd0, io_sel}, {15'd0, v && !ia && a >= 'h400000});
      chk({tag, " io_we"}, {15'd0, io_we}, {15'd0, v && !ia && !rd && a >= 'h400000});
      @(posedge clk);
      if (a >= 'h400000) tgt = 2;
      else if (ovl_m ? (a < 'h300000) : (a >= 'h200000)) tgt = 1;
      else tgt = 0;
      ri = a % RAM_W;
      oi = a % ROM_W;
      if (v && !ia) begin
         if (rd) begin
            if (tgt == 0)      w = ram_m[ri];
            else if (tgt == 1) w = rom_f(oi);
            else               w = hit ? iod : 16'hFFFF;
            if (wd)                  exp_rd = w;
            else if (tgt == 2 || lsb) exp_rd = {8'h00, w[7:0]};
            else                     exp_rd = {8'h00, w[15:8]};
         end else if (tgt == 0) begin
            if (wd)        ram_m[ri] = wdat;
            else if (!lsb) ram_m[ri][15:8] = wdat[7:0];
            else           ram_m[ri][7:0] = wdat[7:0];
         end
      end
      ovl_m = ovl;
      @(negedge clk);
      chk({tag, " rdata"}, rdata, exp_rd);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R12 reset value", rdata, 16'h0000);

      // Overlay set after reset (R11): ROM at zero
      cyc("R11 R2 R13 boot ROM at 0",    1,0,1,1,0, 'h000000, 0,      1,0,0);
      cyc("R5 write to ROM ovl=1",       1,0,0,1,0, 'h000010, 'h1234, 1,0,0);
      cyc("R5 ROM intact ovl=1",         1,0,1,1,0, 'h000010, 0,      1,0,0);
      cyc("R2 RAM write 0x300005",       1,0,0,1,0, 'h300005, 'hBEEF, 1,0,0);
      cyc("R2 RAM read 0x300005",        1,0,1,1,0, 'h300005, 0,      1,0,0);
      cyc("R2 ROM at 0x2FFFFF",          1,0,1,1,0, 'h2FFFFF, 0,      1,0,0);
      cyc("R2 RAM write 0x3FFFFF",       1,0,0,1,0, 'h3FFFFF, 'hCAFE, 1,0,0);
      cyc("R2 RAM read 0x3FFFFF",        1,0,1,1,0, 'h3FFFFF, 0,      1,0,0);
      cyc("R2 ROM at 0x1FFFFF",          1,0,1,1,0, 'h1FFFFF, 0,      1,0,0);
      cyc("R2 ROM at 0x200000",          1,0,1,1,0, 'h200000, 0,      1,0,0);
      cyc("R10 idle while clearing ovl", 0,0,1,1,0, 'h000005, 0,      0,0,0);

      // Overlay clear
      cyc("R3 R4 RAM alias 0x000005",    1,0,1,1,0, 'h000005, 0,      0,0,0);
      cyc("R3 RAM at 0x1FFFFF",          1,0,1,1,0, 'h1FFFFF, 0,      0,0,0);
      cyc("R3 ROM at 0x200000",          1,0,1,1,0, 'h200000, 0,      0,0,0);
      cyc("R3 ROM at 0x2FFFFF",          1,0,1,1,0, 'h2FFFFF, 0,      0,0,0);
      cyc("R3 ROM at 0x300005",          1,0,1,1,0, 'h300005, 0,      0,0,0);
      cyc("R5 write to ROM ovl=0",       1,0,0,1,0, 'h200010, 'h9999, 0,0,0);
      cyc("R5 ROM intact ovl=0",         1,0,1,1,0, 'h200010, 0,      0,0,0);
      cyc("R4 wrapped RAM write",        1,0,0,1,0, 'h000400, 'h1111, 0,0,0);
      cyc("R4 wrapped RAM read",         1,0,1,1,0, 'h000000, 0,      0,0,0);
      cyc("R6 byte write upper",         1,0,0,0,0, 'h000000, 'h00AB, 0,0,0);
      cyc("R6 upper lane merged",        1,0,1,1,0, 'h000000, 0,      0,0,0);
      cyc("R6 byte write lower",         1,0,0,0,1, 'h000000, 'h77CD, 0,0,0);
      cyc("R6 lower lane merged",        1,0,1,1,0, 'h000000, 0,      0,0,0);
      cyc("R7 byte read upper",          1,0,1,0,0, 'h000000, 0,      0,0,0);
      cyc("R7 byte read lower",          1,0,1,0,1, 'h000000, 0,      0,0,0);
      cyc("R7 ROM byte read upper",      1,0,1,0,0, 'h200123, 0,      0,0,0);

      // No strobe / interrupt acknowledge
      cyc("R10 write without strobe",    0,0,0,1,0, 'h000000, 'hFFFF, 0,0,0);
      cyc("R10 iack write",              1,1,0,1,0, 'h000000, 'h0000, 0,0,0);
      cyc("R10 iack read holds rdata",   1,1,1,1,0, 'h000005, 0,      0,0,0);
      cyc("R10 RAM untouched",           1,0,1,1,0, 'h000000, 0,      0,0,0);

      // I/O region
      cyc("R9 unrecognised word",        1,0,1,1,0, 'h400000, 0,      0,0,'h1234);
      cyc("R9 unrecognised byte",        1,0,1,0,0, 'h400000, 0,      0,0,'h1234);
      cyc("R9 recognised word",          1,0,1,1,0, 'h400000, 0,      0,1,'h5A3C);
      cyc("R9 R7 recognised byte",       1,0,1,0,0, 'h400000, 0,      0,1,'h5A3C);
      cyc("R1 I/O write",                1,0,0,1,0, 'h400000, 'h7777, 0,0,0);
      cyc("R1 RAM index 0 untouched",    1,0,1,1,0, 'h000000, 0,      0,0,0);
      cyc("R1 below I/O 0x3FFFFF",       1,0,1,1,0, 'h3FFFFF, 0,      0,0,0);
      cyc("R8 no strobe 0x6FFFFF",       0,0,1,1,0, 'h6FFFFF, 0,      0,0,0);
      cyc("R8 no strobe 0x700000",       0,0,1,1,0, 'h700000, 0,      0,0,0);
      cyc("R8 read 0x700000",            1,0,1,1,0, 'h700000, 0,      0,0,0);
      cyc("R8 read 0x6FFFFF",            1,0,1,1,0, 'h6FFFFF, 0,      0,1,'h0F0F);

      // Overlay lag, both directions
      cyc("R11 set ovl same cycle old map", 1,0,1,1,0, 'h000005, 0,   1,0,0);
      cyc("R11 new map next cycle",         1,0,1,1,0, 'h000005, 0,   1,0,0);
      cyc("R11 clear ovl same cycle",       1,0,1,1,0, 'h000005, 0,   0,0,0);
      cyc("R11 RAM back next cycle",        1,0,1,1,0, 'h000005, 0,   0,0,0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule